// File: doc/BRIEF.md
# Global Time Base with Per-Core Compare Interrupts

This block keeps one free-running time count shared by every core of a cluster and gives each core its own 64-bit alarm. The count is `32 + 4*K` bits wide, with `K` a build-time choice that the block also reports through its configuration word. A halt bit in that word freezes the count. Software reads the count as two 32-bit words. Since the words are fetched separately, software reads the upper word, then the lower word, then the upper word again. If the two upper-word reads differ, a carry happened between the fetches and the sequence is retried.

Each core owns a 64-bit compare value, written and read back as a lower and an upper 32-bit word. The block compares that value with the count, zero-extended to 64 bits. It latches the core's interrupt line once the count reaches or passes the compare value. Any write to either word of that core's compare value drops the line. Software acknowledges a timer tick by programming the next deadline.

Register word addresses: 0 configuration, 1 count bits 31:0, 2 count bits 63:32, 3 reserved, `4+2c` compare bits 31:0 of core `c`, `5+2c` compare bits 63:32 of core `c`.

Top module: `gtimer_top`

## Requirements
- R1: Address 0 holds the halt bit at bit 0, which is writable and resets to 1, and a read-only width field `K` at bits 19:16. All other bits of this word read 0, and writes cannot change the width field.
- R2: The count resets to 0. In every cycle in which the registered halt bit is 0, the count rises by exactly one. While the halt bit is 1 the count holds. A write to the halt bit takes effect from the following cycle.
- R3: The count is `32+4*K` bits wide and wraps from its all-ones value to 0. Count bits above that width read as 0, and write data for them is discarded.
- R4: Writing address 1 or address 2 loads that half of the count. A load wins over the increment in the same cycle. A carry out of bit 31 propagates into the upper half.
- R5: Reads return data one cycle after the request. `bus_rvalid` is high for exactly that cycle. The returned value is the state in the request cycle. Address 3 and addresses above the last compare word read 0, and writes to them change nothing.
- R6: Each core's 64-bit compare value resets to all ones and can be read back at its two addresses.
- R7: A core's interrupt goes high one cycle after a cycle in which the zero-extended count is greater than or equal to that core's compare value. This includes equality. The interrupt then stays high until it is cleared.
- R8: A write to either compare word of core `c` clears that core's interrupt at the write edge. The new compare value is first used in the cycle after the write.
- R9: Each count-word read reflects the count in its own request cycle. A high-low-high sequence therefore shows a differing upper word when a carry falls between the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read request |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| core_irq | output | NUM_CORES | Per-core compare interrupt, registered |

## Verification
Read data is due at the first clock edge after the request. The scoreboard queues each expected word when the request is driven, and the monitor pops it at the falling edge that follows that edge. Every count value the bench expects comes from counting the rising edges between the edge that clears the halt bit and the edge that sets it again, or the edge that samples a read. An interrupt is due one edge after the count reaches the compare value, and a clear lands on the write edge itself. The bench therefore samples `core_irq` at falling edges placed an exact number of cycles after the start write or the compare write, and checks both the cycle before and the cycle of each change.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

  typedef logic [31:0] word_t;
  typedef logic [63:0] dword_t;

  // word addresses; the per-core compare layout is decoded by both
  // the write decode in the top and the read mux
  localparam int unsigned REG_CFG      = 0;
  localparam int unsigned REG_CNT_LO   = 1;
  localparam int unsigned REG_CNT_HI   = 2;
  localparam int unsigned REG_CMP_BASE = 4;

  // configuration word fields
  localparam int unsigned CFG_HALT_BIT = 0;
  localparam int unsigned CFG_K_LSB    = 16;
  localparam int unsigned CFG_K_W      = 4;

  typedef struct packed {
    logic cfg;
    logic cnt_lo;
    logic cnt_hi;
  } glob_wr_t;

  function automatic int unsigned cmp_lo_addr(input int unsigned core);
    return REG_CMP_BASE + 2 * core;
  endfunction

  function automatic int unsigned cmp_hi_addr(input int unsigned core);
    return REG_CMP_BASE + 2 * core + 1;
  endfunction

endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter
  import gtimer_pkg::*;
#(
  parameter int unsigned STEP_K = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  glob_wr_t wr,
  input  word_t    wdata,
  output logic     halt,
  output dword_t   cnt_ext
);

  localparam int unsigned CW    = 32 + 4 * STEP_K;
  localparam int unsigned HI_W  = (CW > 32) ? (CW - 32) : 1;

  logic          halt_q;
  logic [CW-1:0] cnt_q;
  logic          any_ld;

  assign any_ld = wr.cnt_lo | wr.cnt_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b1;
    end else if (wr.cfg) begin
      halt_q <= wdata[CFG_HALT_BIT];
    end
  end

  generate
    if (CW > 32) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (any_ld) begin
          if (wr.cnt_lo) cnt_q[31:0]  <= wdata;
          if (wr.cnt_hi) cnt_q[CW-1:32] <= wdata[HI_W-1:0];
        end else if (!halt_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (wr.cnt_lo) begin
          cnt_q <= wdata[CW-1:0];
        end else if (!halt_q && !wr.cnt_hi) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign halt    = halt_q;
  assign cnt_ext = 64'(cnt_q);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !any_ld) |=> $stable(cnt_q)) else $error("count moved while halted"); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && !any_ld) |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("count did not step by one"); // R3
  AST_CNT_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
    wr.cnt_lo |=> (cnt_q[31:0] == $past(wdata[31:0]))) else $error("low load lost"); // R4
  AST_HALT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr.cfg |=> (halt_q == $past(wdata[CFG_HALT_BIT]))) else $error("halt bit not written"); // R1

endmodule

// File: rtl/gtimer_compare.sv
module gtimer_compare
  import gtimer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  word_t  wdata,
  input  dword_t cnt_ext,
  output dword_t cmp,
  output logic   irq
);

  dword_t cmp_q;
  logic   irq_q;
  logic   any_wr;
  logic   reached;

  assign any_wr  = wr_lo | wr_hi;
  assign reached = (cnt_ext >= cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
    end else begin
      if (wr_lo) cmp_q[31:0]  <= wdata;
      if (wr_hi) cmp_q[63:32] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (any_wr) begin
      irq_q <= 1'b0;
    end else if (reached) begin
      irq_q <= 1'b1;
    end
  end

  assign cmp = cmp_q;
  assign irq = irq_q;

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    any_wr |=> !irq_q) else $error("compare write did not clear irq"); // R8
  AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (rst)
    (!any_wr && (cnt_ext >= cmp_q)) |=> irq_q) else $error("irq missed deadline"); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !any_wr) |=> irq_q) else $error("irq dropped without write"); // R7
  AST_CMP_HI_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (cmp_q[63:32] == $past(wdata))) else $error("compare high not written"); // R6

endmodule

// File: rtl/gtimer_regbus.sv
module gtimer_regbus
  import gtimer_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned STEP_K    = 2,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       halt,
  input  dword_t                     cnt_ext,
  input  logic [NUM_CORES-1:0][63:0] cmp_all,
  output word_t                      rdata,
  output logic                       rvalid
);

  word_t cfg_word;
  word_t rd_mux;
  word_t rdata_q;
  logic  rvalid_q;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_HALT_BIT] = halt;
    cfg_word[CFG_K_LSB +: CFG_K_W] = CFG_K_W'(STEP_K);
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(REG_CFG))    rd_mux = cfg_word;
    if (addr == ADDR_W'(REG_CNT_LO)) rd_mux = cnt_ext[31:0];
    if (addr == ADDR_W'(REG_CNT_HI)) rd_mux = cnt_ext[63:32];
    for (int c = 0; c < int'(NUM_CORES); c++) begin
      if (addr == ADDR_W'(cmp_lo_addr(c))) rd_mux = cmp_all[c][31:0];
      if (addr == ADDR_W'(cmp_hi_addr(c))) rd_mux = cmp_all[c][63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_RVALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_q) else $error("read not answered"); // R5
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_q) else $error("spurious read valid"); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q)) else $error("read data moved without request"); // R5

endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
  import gtimer_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned STEP_K    = 2,
  parameter int unsigned ADDR_W    = $clog2(REG_CMP_BASE + 2 * NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CORES-1:0] core_irq
);

  glob_wr_t                   glob_wr;
  logic                       halt;
  dword_t                     cnt_ext;
  logic [NUM_CORES-1:0][63:0] cmp_all;
  logic [NUM_CORES-1:0]       irq_vec;

  always_comb begin
    glob_wr.cfg    = bus_wr_en && (bus_addr == ADDR_W'(REG_CFG));
    glob_wr.cnt_lo = bus_wr_en && (bus_addr == ADDR_W'(REG_CNT_LO));
    glob_wr.cnt_hi = bus_wr_en && (bus_addr == ADDR_W'(REG_CNT_HI));
  end

  gtimer_counter #(
    .STEP_K (STEP_K)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .wr      (glob_wr),
    .wdata   (bus_wdata),
    .halt    (halt),
    .cnt_ext (cnt_ext)
  );

  generate
    for (genvar c = 0; c < int'(NUM_CORES); c++) begin : g_core
      logic wr_lo;
      logic wr_hi;
      dword_t cmp_c;

      assign wr_lo = bus_wr_en && (bus_addr == ADDR_W'(cmp_lo_addr(c)));
      assign wr_hi = bus_wr_en && (bus_addr == ADDR_W'(cmp_hi_addr(c)));

      gtimer_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .cnt_ext (cnt_ext),
        .cmp     (cmp_c),
        .irq     (irq_vec[c])
      );

      assign cmp_all[c] = cmp_c;
    end
  endgenerate

  gtimer_regbus #(
    .NUM_CORES (NUM_CORES),
    .STEP_K    (STEP_K),
    .ADDR_W    (ADDR_W)
  ) u_regbus (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd_en),
    .addr    (bus_addr),
    .halt    (halt),
    .cnt_ext (cnt_ext),
    .cmp_all (cmp_all),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  assign core_irq = irq_vec;

  AST_RESERVED_WR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(3)) |=> $stable(halt)) else $error("reserved write changed config"); // R5

endmodule

// File: tb/gtimer_top_tb_top.sv
module gtimer_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NCORE = 4;
  localparam int unsigned KSTEP = 2;
  localparam int unsigned AW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             rvalid;
  logic [NCORE-1:0] irq;

  typedef struct {
    logic [31:0] expv;
    string       tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10ns clk = ~clk;

  gtimer_top #(
    .NUM_CORES (NCORE),
    .STEP_K    (KSTEP),
    .ADDR_W    (AW)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (wr_en),
    .bus_rd_en  (rd_en),
    .bus_addr   (addr),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .bus_rvalid (rvalid),
    .core_irq   (irq)
  );

  // monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5: unexpected read data actual %h expected none", rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        if (rdata !== it.expv) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.expv);
        end
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    it.expv = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_irq(input logic [NCORE-1:0] e, input string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check_irq(4'b0000, "R7 reset irq");
    bus_read(0, 32'h0002_0001, "R1 cfg reset");
    bus_read(1, 32'h0, "R2 count lo reset");
    bus_read(2, 32'h0, "R2 count hi reset");
    bus_read(4, 32'hFFFF_FFFF, "R6 cmp0 lo reset");
    bus_read(11, 32'hFFFF_FFFF, "R6 cmp3 hi reset");

    // loads while halted, width masking
    bus_write(2, 32'hFFFF_FFFF);
    bus_read(2, 32'h0000_00FF, "R3 bits above width read zero");
    bus_write(1, 32'h1234_5678);
    bus_read(1, 32'h1234_5678, "R4 load low half");
    repeat (10) @(negedge clk);
    bus_read(1, 32'h1234_5678, "R2 hold while halted");
    bus_read(2, 32'h0000_00FF, "R4 high half kept");

    // config width field read-only, reserved/unmapped
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, 32'h0002_0001, "R1 width field read-only");
    bus_write(3, 32'hDEAD_BEEF);
    bus_read(3, 32'h0, "R5 reserved reads zero");
    bus_read(15, 32'h0, "R5 unmapped reads zero");
    bus_read(0, 32'h0002_0001, "R5 reserved write ignored");

    // exact increment count: start edge P0, halt write edge P10
    bus_write(2, 32'h0);
    bus_write(1, 32'h0);
    bus_write(0, 32'h0);
    repeat (8) @(negedge clk);
    bus_write(0, 32'h1);
    bus_read(1, 32'd10, "R2 ten increments");
    bus_read(2, 32'h0, "R2 high unchanged");

    // wrap at configured width: three increments from max-2
    bus_write(2, 32'h0000_00FF);
    bus_write(1, 32'hFFFF_FFFD);
    bus_write(0, 32'h0);
    @(negedge clk);
    bus_write(0, 32'h1);
    bus_read(1, 32'h0, "R3 wrap low");
    bus_read(2, 32'h0, "R3 wrap high");

    // carry into high half: two increments
    bus_write(2, 32'h0);
    bus_write(1, 32'hFFFF_FFFE);
    bus_write(0, 32'h0);
    bus_write(0, 32'h1);
    bus_read(2, 32'h1, "R4 carry into high");
    bus_read(1, 32'h0, "R4 low after carry");

    // high-low-high while running, C = 0xFFFFFFFD
    bus_write(2, 32'h0);
    bus_write(1, 32'hFFFF_FFFD);
    bus_write(0, 32'h0);
    bus_read(2, 32'h0, "R9 first high read");
    bus_read(1, 32'h0, "R9 low read after carry");
    bus_read(2, 32'h1, "R9 second high differs");
    bus_write(0, 32'h1);
    bus_read(1, 32'h5, "R9 low after halt");
    bus_read(2, 32'h1, "R9 high after halt");

    // core1 compare at 105, count from 100
    bus_write(2, 32'h0);
    bus_write(1, 32'd100);
    bus_write(7, 32'h0);
    bus_write(6, 32'd105);
    bus_read(6, 32'd105, "R6 cmp1 lo readback");
    bus_read(7, 32'h0, "R6 cmp1 hi readback");
    check_irq(4'b0000, "R7 below compare");
    bus_write(0, 32'h0);
    repeat (5) @(negedge clk);
    check_irq(4'b0000, "R7 not yet one cycle after reach");
    @(negedge clk);
    check_irq(4'b0010, "R7 fires one cycle after reach");
    bus_write(0, 32'h1);
    repeat (3) @(negedge clk);
    check_irq(4'b0010, "R7 sticky");
    bus_read(1, 32'd108, "R2 count after compare run");
    bus_write(6, 32'hFFFF_FFFF);
    check_irq(4'b0000, "R8 clear on compare write");
    @(negedge clk);
    check_irq(4'b0000, "R8 stays clear below new value");

    // core2: greater case, new value only after write
    bus_write(8, 32'h0);
    repeat (2) @(negedge clk);
    check_irq(4'b0000, "R7 high compare word still above");
    bus_write(9, 32'h0);
    check_irq(4'b0000, "R8 write cycle clears");
    @(negedge clk);
    check_irq(4'b0100, "R8 new compare used next cycle");

    // core3: equality at count 108
    bus_write(11, 32'h0);
    bus_write(10, 32'd108);
    check_irq(4'b0100, "R8 equal value not yet used");
    @(negedge clk);
    check_irq(4'b1100, "R7 equal fires");

    // core0 compare at 2^40: never reached by a 40-bit count
    bus_write(5, 32'h0000_0100);
    bus_write(4, 32'h0);
    bus_write(2, 32'h0000_00FF);
    bus_write(1, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    check_irq(4'b1110, "R7 core0 beyond width never fires, core1 fires");
    bus_read(5, 32'h0000_0100, "R6 cmp0 hi readback");

    repeat (3) @(negedge clk);
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R5: actual %0d reads unanswered expected 0", sb_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule